// File: doc/BRIEF.md
# FIFO with Distinct-Value Tracking

This block is a single-clock first-in first-out queue that also keeps track of how many different data values it currently holds. Next to the entry storage it keeps one occurrence counter for every possible data value and a running count of the values whose occurrence counter is not zero. When that count reaches a threshold parameter, a registered flag goes high.

The data width is kept small (4 bits by default), so the whole occurrence table fits in registers and no lookup structure is needed. A producer drives `push` with `wr_data`, and a consumer drives `pop` and takes `rd_data`. The read data always shows the oldest entry, so a consumer can look at the value in the same cycle that it pops it. `distinct_cnt` and `many_vals` can be read at any time. Typical uses are checking the diversity of traffic and watching for pattern saturation in a buffered stream.

Top module: `fifo_uniq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the pointers, all occurrence counters, the distinct count and the flag. After that edge `empty`=1, `full`=0, `distinct_cnt`=0 and `many_vals`=0.
- R2: Entries leave in the order they were accepted. After DEPTH (default 32) accepted pushes with no pops, `full` is 1. `full` and `empty` are never both 1.
- R3: While `empty` is 0, `rd_data` equals the oldest stored entry. It is valid in the same cycle that `pop` is applied (show-ahead).
- R4: An accepted push of a value not currently stored raises `distinct_cnt` by one. An accepted push of a value already stored leaves `distinct_cnt` unchanged.
- R5: An accepted pop removes the oldest entry. `distinct_cnt` falls by one only when the last stored copy of that value leaves. A queue with `empty`=1 has `distinct_cnt`=0.
- R6: A pop while `empty` is 1 is ignored. The counters, the flag and `empty` do not change.
- R7: A push while `full` is 1 is ignored, even when a pop is applied in the same cycle. The stored data and the counters are left unchanged by that push, and the rejected value never appears on `rd_data`.
- R8: When a push and a pop are both accepted in one cycle, both take effect. If they carry the same value, `distinct_cnt` is unchanged.
- R9: `many_vals` is a register. After every clock edge it equals (`distinct_cnt` >= THRESH), where THRESH defaults to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Request to store `wr_data` |
| wr_data | input | DW | Value to store |
| pop | input | 1 | Request to remove the oldest entry |
| rd_data | output | DW | Oldest stored entry (show-ahead) |
| full | output | 1 | DEPTH entries are stored |
| empty | output | 1 | No entries are stored |
| distinct_cnt | output | DCW | Number of different values currently stored |
| many_vals | output | 1 | Registered flag: distinct count is at least THRESH |

## Verification
The properties assume that `push`, `pop` and `wr_data` are known (never X) at every rising edge. They also assume that `rst` is high at the first edge, so that every `$past` value comes from a cleared state. The bench drives all inputs at the falling edge and holds them low between its scenarios. It asserts reset before any other traffic. It also drives requests that are meant to be refused, such as a pop on an empty queue, a push on a full queue, and a push together with a pop on a full queue. The checks that cover these refused requests apply only to the cycles in which such a request really occurs.

// File: rtl/fifo_uniq_pkg.sv
package fifo_uniq_pkg;

    localparam int unsigned DEF_DW     = 4;
    localparam int unsigned DEF_DEPTH  = 32;
    localparam int unsigned DEF_THRESH = 7;

    // Per-value occurrence counter update chosen each cycle
    typedef enum logic [1:0] {
        OCC_HOLD = 2'b00,
        OCC_INC  = 2'b01,
        OCC_DEC  = 2'b10
    } occ_step_e;

    // Change to the distinct-value count in one cycle
    typedef struct packed {
        logic gain;
        logic lose;
    } dist_delta_t;

    // Accepted operations for one cycle, after gating by full/empty
    typedef struct packed {
        logic wr;
        logic rd;
    } fifo_op_t;

    function automatic occ_step_e occ_step(input logic inc, input logic dec);
        if (inc && !dec)      return OCC_INC;
        else if (dec && !inc) return OCC_DEC;
        else                  return OCC_HOLD;
    endfunction

    function automatic int unsigned cnt_w(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/fifo_uniq_store.sv
module fifo_uniq_store
    import fifo_uniq_pkg::*;
#(
    parameter int unsigned DW    = DEF_DW,
    parameter int unsigned DEPTH = DEF_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_val,
    input  logic          rd_en,
    output logic [DW-1:0] rd_val,
    output logic          full,
    output logic          empty
);
    localparam int unsigned AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int unsigned LW = cnt_w(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [LW-1:0] level;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_en) wr_ptr <= ptr_next(wr_ptr);
            if (rd_en) rd_ptr <= ptr_next(rd_ptr);
            case ({wr_en, rd_en})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign rd_val = mem[rd_ptr];
    assign full   = (level == LW'(DEPTH));
    assign empty  = (level == '0);

endmodule

// File: rtl/fifo_uniq_occ.sv
module fifo_uniq_occ
    import fifo_uniq_pkg::*;
#(
    parameter int unsigned DW     = DEF_DW,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned THRESH = DEF_THRESH,
    localparam int unsigned NV    = 1 << DW,
    localparam int unsigned DCW   = cnt_w(NV)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_val,
    input  logic           rd_en,
    input  logic [DW-1:0]  rd_val,
    output logic [DCW-1:0] distinct,
    output logic           flag
);
    localparam int unsigned OCW = cnt_w(DEPTH);

    logic        is_zero [NV];
    logic        is_one  [NV];
    dist_delta_t delta;
    logic [DCW-1:0] dist_q;
    logic [DCW-1:0] dist_nxt;
    logic        flag_q;

    for (genvar v = 0; v < NV; v++) begin : g_val
        logic [OCW-1:0] occ_q;
        occ_step_e      stp;

        assign stp = occ_step(wr_en && (wr_val == DW'(v)),
                              rd_en && (rd_val == DW'(v)));

        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q <= '0;
            end else begin
                case (stp)
                    OCC_INC: occ_q <= occ_q + 1'b1;
                    OCC_DEC: occ_q <= occ_q - 1'b1;
                    default: occ_q <= occ_q;
                endcase
            end
        end

        assign is_zero[v] = (occ_q == '0);
        assign is_one[v]  = (occ_q == OCW'(1));
    end

    always_comb begin
        delta.gain = wr_en && is_zero[wr_val];
        delta.lose = rd_en && is_one[rd_val] && !(wr_en && (wr_val == rd_val));
        case ({delta.gain, delta.lose})
            2'b10:   dist_nxt = dist_q + 1'b1;
            2'b01:   dist_nxt = dist_q - 1'b1;
            default: dist_nxt = dist_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dist_q <= '0;
            flag_q <= 1'b0;
        end else begin
            dist_q <= dist_nxt;
            flag_q <= (dist_nxt >= DCW'(THRESH));
        end
    end

    assign distinct = dist_q;
    assign flag     = flag_q;

endmodule

// File: rtl/fifo_uniq_top.sv
module fifo_uniq_top
    import fifo_uniq_pkg::*;
#(
    parameter int unsigned DW     = DEF_DW,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned THRESH = DEF_THRESH,
    localparam int unsigned DCW   = cnt_w(1 << DW)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic [DW-1:0]  wr_data,
    input  logic           pop,
    output logic [DW-1:0]  rd_data,
    output logic           full,
    output logic           empty,
    output logic [DCW-1:0] distinct_cnt,
    output logic           many_vals
);
    fifo_op_t      op;
    logic          st_full;
    logic          st_empty;
    logic [DW-1:0] head;

    // A refused request takes effect nowhere, so storage and table stay aligned
    always_comb begin
        op.wr = push && !st_full;
        op.rd = pop  && !st_empty;
    end

    fifo_uniq_store #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (op.wr),
        .wr_val (wr_data),
        .rd_en  (op.rd),
        .rd_val (head),
        .full   (st_full),
        .empty  (st_empty)
    );

    fifo_uniq_occ #(
        .DW     (DW),
        .DEPTH  (DEPTH),
        .THRESH (THRESH)
    ) u_occ (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (op.wr),
        .wr_val   (wr_data),
        .rd_en    (op.rd),
        .rd_val   (head),
        .distinct (distinct_cnt),
        .flag     (many_vals)
    );

    assign rd_data = head;
    assign full    = st_full;
    assign empty   = st_empty;

endmodule

// File: rtl/fifo_uniq_chk.sv
module fifo_uniq_chk
    import fifo_uniq_pkg::*;
#(
    parameter int unsigned DW     = DEF_DW,
    parameter int unsigned THRESH = DEF_THRESH,
    localparam int unsigned DCW   = cnt_w(1 << DW)
) (
    input logic           clk,
    input logic           rst,
    input logic           push,
    input logic [DW-1:0]  wr_data,
    input logic           pop,
    input logic [DW-1:0]  rd_data,
    input logic           full,
    input logic           empty,
    input logic [DCW-1:0] distinct_cnt,
    input logic           many_vals
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (empty && !full && distinct_cnt == '0 && !many_vals));

    // R2
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R4
    push_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=>
        (distinct_cnt == $past(distinct_cnt) ||
         distinct_cnt == $past(distinct_cnt) + 1'b1));

    // R5
    pop_lose_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !empty && !push) |=>
        (distinct_cnt == $past(distinct_cnt) ||
         distinct_cnt == $past(distinct_cnt) - 1'b1));

    // R5
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> (distinct_cnt == '0));

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> ($stable(distinct_cnt) && empty && $stable(many_vals)));

    // R7
    full_push_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> ($stable(distinct_cnt) && full));

    // R8
    same_val_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !full && !empty && wr_data == rd_data) |=> $stable(distinct_cnt));

    // R9
    flag_match_chk: assert property (@(posedge clk) disable iff (rst)
        many_vals == (distinct_cnt >= DCW'(THRESH)));

endmodule

bind fifo_uniq_top fifo_uniq_chk #(
    .DW     (DW),
    .THRESH (THRESH)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .push         (push),
    .wr_data      (wr_data),
    .pop          (pop),
    .rd_data      (rd_data),
    .full         (full),
    .empty        (empty),
    .distinct_cnt (distinct_cnt),
    .many_vals    (many_vals)
);

// File: tb/fifo_uniq_top_tb.sv
module fifo_uniq_top_tb;
    localparam int DW     = 4;
    localparam int DEPTH  = 32;
    localparam int THRESH = 7;

    logic       clk = 1'b0;
    logic       rst;
    logic       push;
    logic [3:0] wr_data;
    logic       pop;
    logic [3:0] rd_data;
    logic       full;
    logic       empty;
    logic [4:0] distinct_cnt;
    logic       many_vals;

    int vecs = 0;
    int errs = 0;
    logic [3:0] mq[$];

    fifo_uniq_top u_dut (
        .clk(clk), .rst(rst), .push(push), .wr_data(wr_data), .pop(pop),
        .rd_data(rd_data), .full(full), .empty(empty),
        .distinct_cnt(distinct_cnt), .many_vals(many_vals)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_distinct();
        bit seen[16];
        int n = 0;
        foreach (mq[i]) seen[mq[i]] = 1'b1;
        for (int v = 0; v < 16; v++) if (seen[v]) n++;
        return n;
    endfunction

    task automatic compare(input string tag);
        int d = model_distinct();
        chk({tag, " empty"}, empty, mq.size() == 0);
        chk({tag, " full"}, full, mq.size() == DEPTH);
        chk({tag, " distinct"}, distinct_cnt, d);
        chk({tag, " flag"}, many_vals, d >= THRESH);
    endtask

    // One cycle: drive at falling edge, update model at rising edge, compare after
    task automatic step(input bit p, input logic [3:0] d, input bit q, input string tag);
        int pre;
        @(negedge clk);
        push = p; wr_data = d; pop = q;
        if (mq.size() > 0) chk("R3 head", rd_data, mq[0]);
        @(posedge clk);
        pre = mq.size();
        if (q && pre > 0) void'(mq.pop_front());
        if (p && pre < DEPTH) mq.push_back(d);
        #2;
        push = 0; pop = 0;
        compare(tag);
    endtask

    task automatic drain(input string tag);
        while (mq.size() > 0) step(0, 0, 1, tag);
    endtask

    task automatic t_reset();
        rst = 1; push = 0; pop = 0; wr_data = 0;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        mq.delete();
        compare("R1 reset");
    endtask

    task automatic t_order();
        for (int i = 0; i < DEPTH; i++) step(1, 4'(i * 7 + 3), 0, "R2 fill");
        chk("R2 full after DEPTH pushes", full, 1);
        drain("R2 order");
    endtask

    task automatic t_distinct();
        step(1, 5, 0, "R4 new");
        step(1, 5, 0, "R4 repeat");
        step(1, 5, 0, "R4 repeat");
        step(1, 3, 0, "R4 second new");
        chk("R4 two values", distinct_cnt, 2);
        step(0, 0, 1, "R5 pop copy");
        step(0, 0, 1, "R5 pop copy");
        chk("R5 copies left", distinct_cnt, 2);
        step(0, 0, 1, "R5 last copy");
        chk("R5 last copy gone", distinct_cnt, 1);
        drain("R5 drain");
    endtask

    task automatic t_empty_pop();
        step(0, 0, 1, "R6 pop empty");
        step(0, 0, 1, "R6 pop empty");
        chk("R6 still empty", empty, 1);
        chk("R6 distinct zero", distinct_cnt, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) step(1, 1, 0, "R7 fill");
        step(1, 9, 0, "R7 push full");
        chk("R7 distinct kept", distinct_cnt, 1);
        step(1, 9, 1, "R7 push full with pop");
        chk("R7 distinct after pop", distinct_cnt, 1);
        while (mq.size() > 0) begin
            chk("R7 no rejected value", rd_data, 1);
            step(0, 0, 1, "R7 drain");
        end
    endtask

    task automatic t_simul();
        step(1, 2, 0, "R8 setup");
        step(1, 4, 0, "R8 setup");
        step(1, 4, 1, "R8 push 4 pop 2");
        chk("R8 two removed one kept", distinct_cnt, 1);
        step(1, 4, 1, "R8 same value");
        chk("R8 same value count", distinct_cnt, 1);
        step(1, 7, 1, "R8 swap value");
        step(1, 8, 1, "R8 swap value");
        chk("R8 swap distinct", distinct_cnt, 2);
        drain("R8 drain");
    endtask

    task automatic t_thresh();
        for (int v = 0; v < THRESH - 1; v++) step(1, 4'(v), 0, "R9 below");
        chk("R9 below threshold", many_vals, 0);
        step(1, 4'(THRESH - 1), 0, "R9 reach");
        chk("R9 at threshold", many_vals, 1);
        step(1, 4'(THRESH + 2), 0, "R9 above");
        chk("R9 above threshold", many_vals, 1);
        step(0, 0, 1, "R9 drop");
        step(0, 0, 1, "R9 drop");
        chk("R9 back below", many_vals, 0);
        drain("R9 drain");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_order();
                t_distinct();
                t_empty_pop();
                t_full();
                t_simul();
                t_thresh();
            end
            begin
                repeat (20000) @(posedge clk);
                errs++;
                vecs++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule